// File: doc/BRIEF.md
# Programming Link Entry and Turnaround Controller

This controller sits above a bit-level frame engine on a two-wire programming link that has a single shared, bidirectional data line. It brings the link up, performs the direction changes that the shared line needs, and takes the link down again. The frame engine does the actual shifting of bits. This block decides when the engine runs and what it runs. It also decides who drives the data line, and it owns the output enables of both pads.

On enable, the controller drives the data line low for a parameter-set number of system cycles, and then high for a second parameter-set count. It then asks the engine for a configurable number of all-idle frames. Requests to send or receive a byte may then be given. Each request first performs whatever turnaround the current direction needs:

- Going from receive to transmit, the controller clocks one dummy bit with the line still released, and only then drives the line high.
- Going from transmit to receive, the controller lets the engine finish, releases the line, and waits for the target to pull it high.

Waits that depend on the target are limited by a millisecond-based timeout. A timeout sets a sticky error flag. The flag blocks further byte requests until the next enable.

Top module: `link_turnaround_ctl`

## Requirements
- R1: After reset, both pad output enables, the engine start, `req_ready`, `op_done` and `tmo_err` are low.
- R2: An `en_req` while the link is off drives `clk_oe` and `data_oe` high with `data_out` low for exactly LOW_CYC cycles. The line is then driven high for exactly HIGH_CYC cycles before the first engine command.
- R3: After the entry hold, BREAK_FRAMES idle-frame commands (kind code 0) are issued. Each one is issued only while `eng_busy` is low, and the next one only after the previous frame ends. `req_ready` rises after the last frame ends, and the link is left in the transmit direction.
- R4: A send request in the receive direction first issues a dummy-bit command (kind 1) with `data_oe` low. After the engine goes idle, the controller drives the line high and issues the send command (kind 2) carrying the latched byte.
- R5: A send request in the transmit direction issues the send command (kind 2) as soon as the engine is idle, with no dummy bit. `op_done` pulses in the cycle of that command.
- R6: A receive request in the transmit direction waits for the engine to go idle, releases `data_oe`, and waits for `line_in` to read high. It then issues the receive command (kind 3). `op_done` pulses in the first cycle in which `eng_busy` is low after that command.
- R7: A timeout counter is reloaded to TMO_MS when a request is accepted, when a wait succeeds and when an operation completes. It counts `ms_tick` pulses only during line-high waits and receive waits. If it reaches zero during such a wait, `tmo_err` is set and stays set until the next enable, and the controller returns to idle.
- R8: While `tmo_err` is high, `req_ready` is low and send and receive requests issue no engine command.
- R9: A disable in the transmit direction waits for the engine to go idle, then releases the line and waits for it to read high or for the timeout. A disable in the receive direction needs no wait. In both cases `clk_oe` and `data_oe` then both go low.
- R10: When requests arrive together in the idle state, disable wins over send, and send wins over receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Pulse: bring the link up |
| dis_req | input | 1 | Pulse: take the link down |
| send_req | input | 1 | Pulse: send `send_data` |
| send_data | input | BYTE_W | Byte to send, latched with `send_req` |
| recv_req | input | 1 | Pulse: receive one frame |
| line_in | input | 1 | Sampled level of the data line |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| eng_busy | input | 1 | Frame engine is running a command |
| eng_dout | input | 1 | Bit the engine wants on the line |
| data_out | output | 1 | Data pad drive value |
| data_oe | output | 1 | Data pad output enable |
| clk_oe | output | 1 | Clock pad output enable |
| eng_start | output | 1 | One-cycle command strobe to the engine |
| eng_kind | output | 2 | Command: 0 idle frame, 1 dummy bit, 2 send, 3 receive |
| eng_byte | output | BYTE_W | Byte for a send command |
| req_ready | output | 1 | Idle and free of error; requests accepted |
| op_done | output | 1 | Pulse: a send was issued or a receive finished |
| tmo_err | output | 1 | Sticky timeout error |

## Verification
The bench builds the controller with LOW_CYC=20, HIGH_CYC=4, TMO_MS=6 and BREAK_FRAMES=2. These values bring the full entry sequence and several timeouts within a few hundred cycles, instead of the tens of thousands a real millisecond needs. A small engine model in the bench can be frozen mid-frame, and the target pull-up can be withheld. Together these reach both timeout paths, the blocking error state and the direction-dependent disable paths, under the same per-cycle reference model.

// File: rtl/link_ctl_pkg.sv
// Package: shared command and state encodings for the link controller.
// Assumes: the frame engine decodes eng_kind with the values below.
package link_ctl_pkg;

    typedef enum logic [1:0] {
        CMD_BREAK = 2'd0,
        CMD_DUMMY = 2'd1,
        CMD_SEND  = 2'd2,
        CMD_RECV  = 2'd3
    } eng_cmd_e;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_LOW,
        ST_HIGH,
        ST_BRK_GO,
        ST_BRK_WAIT,
        ST_IDLE,
        ST_DUM_GO,
        ST_DUM_WAIT,
        ST_TX_GO,
        ST_RX_DRAIN,
        ST_RX_PULL,
        ST_RX_GO,
        ST_RX_WAIT,
        ST_DIS_DRAIN,
        ST_DIS_PULL
    } link_st_e;

endpackage

// File: rtl/link_hold_timer.sv
// Module: down-counter that measures the entry hold phases.
// A load sets the count. The count then falls by one per cycle and stops at zero.
// Assumes: the caller loads (cycles - 1), so that 'expired' is seen on the last cycle.
module link_hold_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Purpose: load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/link_cmd_timeout.sv
// Module: millisecond timeout budget for waits that depend on the target.
// Reload restores the full budget. Ticks count only while tick_en is high.
// Assumes: ms_tick is a single-cycle pulse.
module link_cmd_timeout #(
    parameter int TMO_MS = 100,
    parameter int W      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic tick_en,
    input  logic ms_tick,
    output logic expired
);
    localparam logic [W-1:0] FULL = W'(TMO_MS);
    logic [W-1:0] left;

    // Purpose: reload on success, else spend one unit per tick during a wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= FULL;
        end else if (reload) begin
            left <= FULL;
        end else if (tick_en && ms_tick && left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign expired = (left == '0);
endmodule

// File: rtl/link_pad_drive.sv
// Module: pad multiplexer for the shared data line and the clock pad enable.
// Assumes: the engine's bit is only valid while eng_busy is high.
//          An idle transmitter holds the line high.
module link_pad_drive (
    input  logic low_hold,
    input  logic link_on,
    input  logic drive_tx,
    input  logic eng_busy,
    input  logic eng_dout,
    output logic data_out,
    output logic data_oe,
    output logic clk_oe
);
    // Purpose: choose the pad enables and the value driven on the data line.
    always_comb begin
        clk_oe  = link_on;
        data_oe = link_on && drive_tx;
        if (!data_oe) begin
            data_out = 1'b0;
        end else if (low_hold) begin
            data_out = 1'b0;
        end else begin
            data_out = eng_busy ? eng_dout : 1'b1;
        end
    end
endmodule

// File: rtl/link_turnaround_ctl.sv
// Module: programming link controller (top). Sequences link entry and exit,
// and turns the shared data line around between transmit and receive.
// Assumes: the engine raises eng_busy in the cycle after eng_start and holds it
// until its frame ends. Requests are single-cycle pulses.
module link_turnaround_ctl
    import link_ctl_pkg::*;
#(
    parameter int LOW_CYC      = 50000,
    parameter int HIGH_CYC     = 50,
    parameter int TMO_MS       = 100,
    parameter int BREAK_FRAMES = 2,
    parameter int BYTE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic              send_req,
    input  logic [BYTE_W-1:0] send_data,
    input  logic              recv_req,
    input  logic              line_in,
    input  logic              ms_tick,
    input  logic              eng_busy,
    input  logic              eng_dout,
    output logic              data_out,
    output logic              data_oe,
    output logic              clk_oe,
    output logic              eng_start,
    output logic [1:0]        eng_kind,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              req_ready,
    output logic              op_done,
    output logic              tmo_err
);
    localparam int HOLD_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
    localparam int TMO_W    = $clog2(TMO_MS + 1);
    localparam int BRK_W    = $clog2(BREAK_FRAMES + 1);
    localparam logic [HOLD_W-1:0] LOW_LOAD  = HOLD_W'(LOW_CYC - 1);
    localparam logic [HOLD_W-1:0] HIGH_LOAD = HOLD_W'(HIGH_CYC - 1);
    localparam logic [BRK_W-1:0]  BRK_INIT  = BRK_W'(BREAK_FRAMES);

    link_st_e          st, st_n;
    logic              dir_tx, dir_n;
    logic              err, err_n;
    logic [BRK_W-1:0]  brk_left, brk_n;
    logic [BYTE_W-1:0] byte_q, byte_n;
    logic              hold_load, hold_exp;
    logic [HOLD_W-1:0] hold_val;
    logic              tmo_reload, tmo_exp, tmo_tick_en;
    eng_cmd_e          kind;

    link_hold_timer #(.W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_val (hold_val),
        .expired  (hold_exp)
    );

    link_cmd_timeout #(.TMO_MS(TMO_MS), .W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (tmo_reload),
        .tick_en (tmo_tick_en),
        .ms_tick (ms_tick),
        .expired (tmo_exp)
    );

    link_pad_drive u_pad (
        .low_hold (st == ST_LOW),
        .link_on  (st != ST_OFF),
        .drive_tx (dir_tx),
        .eng_busy (eng_busy),
        .eng_dout (eng_dout),
        .data_out (data_out),
        .data_oe  (data_oe),
        .clk_oe   (clk_oe)
    );

    // Purpose: the timeout only runs while waiting on the target.
    assign tmo_tick_en = (st == ST_RX_PULL) || (st == ST_RX_WAIT) || (st == ST_DIS_PULL);

    // Purpose: next-state, command and timer control for the link sequence.
    always_comb begin
        st_n       = st;
        dir_n      = dir_tx;
        err_n      = err;
        brk_n      = brk_left;
        byte_n     = byte_q;
        hold_load  = 1'b0;
        hold_val   = '0;
        tmo_reload = 1'b0;
        eng_start  = 1'b0;
        kind       = CMD_BREAK;
        op_done    = 1'b0;
        unique case (st)
            ST_OFF: begin
                if (en_req) begin
                    st_n       = ST_LOW;
                    dir_n      = 1'b1;
                    err_n      = 1'b0;
                    hold_load  = 1'b1;
                    hold_val   = LOW_LOAD;
                    tmo_reload = 1'b1;
                end
            end
            ST_LOW: begin
                if (hold_exp) begin
                    st_n      = ST_HIGH;
                    hold_load = 1'b1;
                    hold_val  = HIGH_LOAD;
                end
            end
            ST_HIGH: begin
                if (hold_exp) begin
                    st_n  = ST_BRK_GO;
                    brk_n = BRK_INIT;
                end
            end
            ST_BRK_GO: begin
                if (!eng_busy) begin
                    eng_start = 1'b1;
                    kind      = CMD_BREAK;
                    st_n      = ST_BRK_WAIT;
                end
            end
            ST_BRK_WAIT: begin
                if (!eng_busy) begin
                    if (brk_left <= BRK_W'(1)) begin
                        st_n       = ST_IDLE;
                        tmo_reload = 1'b1;
                    end else begin
                        brk_n = brk_left - 1'b1;
                        st_n  = ST_BRK_GO;
                    end
                end
            end
            ST_IDLE: begin
                if (dis_req) begin
                    tmo_reload = 1'b1;
                    if (dir_tx) begin
                        st_n = ST_DIS_DRAIN;
                    end else begin
                        st_n = ST_OFF;
                    end
                end else if (send_req && !err) begin
                    tmo_reload = 1'b1;
                    byte_n     = send_data;
                    st_n       = dir_tx ? ST_TX_GO : ST_DUM_GO;
                end else if (recv_req && !err) begin
                    tmo_reload = 1'b1;
                    st_n       = dir_tx ? ST_RX_DRAIN : ST_RX_GO;
                end
            end
            ST_DUM_GO: begin
                if (!eng_busy) begin
                    eng_start = 1'b1;
                    kind      = CMD_DUMMY;
                    st_n      = ST_DUM_WAIT;
                end
            end
            ST_DUM_WAIT: begin
                if (!eng_busy) begin
                    dir_n = 1'b1;
                    st_n  = ST_TX_GO;
                end
            end
            ST_TX_GO: begin
                if (!eng_busy) begin
                    eng_start  = 1'b1;
                    kind       = CMD_SEND;
                    op_done    = 1'b1;
                    tmo_reload = 1'b1;
                    st_n       = ST_IDLE;
                end
            end
            ST_RX_DRAIN: begin
                if (!eng_busy) begin
                    dir_n = 1'b0;
                    st_n  = ST_RX_PULL;
                end
            end
            ST_RX_PULL: begin
                if (line_in) begin
                    tmo_reload = 1'b1;
                    st_n       = ST_RX_GO;
                end else if (tmo_exp) begin
                    err_n = 1'b1;
                    st_n  = ST_IDLE;
                end
            end
            ST_RX_GO: begin
                if (!eng_busy) begin
                    eng_start = 1'b1;
                    kind      = CMD_RECV;
                    st_n      = ST_RX_WAIT;
                end
            end
            ST_RX_WAIT: begin
                if (!eng_busy) begin
                    op_done    = 1'b1;
                    tmo_reload = 1'b1;
                    st_n       = ST_IDLE;
                end else if (tmo_exp) begin
                    err_n = 1'b1;
                    st_n  = ST_IDLE;
                end
            end
            ST_DIS_DRAIN: begin
                if (!eng_busy) begin
                    dir_n = 1'b0;
                    st_n  = ST_DIS_PULL;
                end
            end
            ST_DIS_PULL: begin
                if (line_in) begin
                    st_n = ST_OFF;
                end else if (tmo_exp) begin
                    err_n = 1'b1;
                    st_n  = ST_OFF;
                end
            end
            default: st_n = ST_OFF;
        endcase
        if (st_n == ST_OFF) begin
            dir_n = 1'b0;
        end
    end

    // Purpose: state and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_OFF;
            dir_tx   <= 1'b0;
            err      <= 1'b0;
            brk_left <= '0;
            byte_q   <= '0;
        end else begin
            st       <= st_n;
            dir_tx   <= dir_n;
            err      <= err_n;
            brk_left <= brk_n;
            byte_q   <= byte_n;
        end
    end

    assign eng_kind  = kind;
    assign eng_byte  = byte_q;
    assign req_ready = (st == ST_IDLE) && !err;
    assign tmo_err   = err;
endmodule

// File: rtl/link_turnaround_ctl_chk.sv
// Module: property checker for the link controller, bound to its ports.
// Assumes: eng_kind codes 0 idle frame, 1 dummy, 2 send, 3 receive.
module link_turnaround_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_req,
    input logic       eng_busy,
    input logic       data_out,
    input logic       data_oe,
    input logic       clk_oe,
    input logic       eng_start,
    input logic [1:0] eng_kind,
    input logic       req_ready,
    input logic       op_done,
    input logic       tmo_err
);
    // R3: commands only reach an idle engine
    assert_start_idle_engine_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy);

    // R4: the dummy bit is clocked with the line still released
    assert_dummy_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_kind == 2'd1) |-> !data_oe);

    // R5: a send starts from a driven-high line
    assert_send_from_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_kind == 2'd2) |-> (data_oe && data_out));

    // R5: completion is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R6: a receive starts with the data line released
    assert_recv_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_kind == 2'd3) |-> !data_oe);

    // R7: the error flag stays until an enable
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_err && !en_req) |=> tmo_err);

    // R8: no request acceptance while in error
    assert_err_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> !req_ready);

    // R9: the data pad is never driven while the clock pad is released
    assert_data_needs_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> clk_oe);
endmodule

bind link_turnaround_ctl link_turnaround_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (en_req),
    .eng_busy  (eng_busy),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .clk_oe    (clk_oe),
    .eng_start (eng_start),
    .eng_kind  (eng_kind),
    .req_ready (req_ready),
    .op_done   (op_done),
    .tmo_err   (tmo_err)
);

// File: tb/link_turnaround_ctl_test.sv
// Bench: per-cycle reference model plus directed checks for the link controller.
module link_turnaround_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOW  = 20;
    localparam int HIGH = 4;
    localparam int TMO  = 6;
    localparam int NBRK = 2;
    localparam int FRAME_LEN = 12;
    localparam int WATCHDOG = 20000;

    // Model phase numbers
    localparam int P_OFF = 0, P_LOW = 1, P_HIGH = 2, P_BRKGO = 3, P_BRKW = 4, P_IDLE = 5,
                   P_DUMGO = 6, P_DUMW = 7, P_TXGO = 8, P_RXDR = 9, P_RXPULL = 10,
                   P_RXGO = 11, P_RXW = 12, P_DISDR = 13, P_DISPULL = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, dis_req = 1'b0, send_req = 1'b0, recv_req = 1'b0;
    logic [7:0] send_data = 8'h00;
    logic line_in, ms_tick, eng_busy, eng_dout;
    logic data_out, data_oe, clk_oe, eng_start, req_ready, op_done, tmo_err;
    logic [1:0] eng_kind;
    logic [7:0] eng_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit pull_high = 1'b1;
    bit hang = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_turnaround_ctl #(
        .LOW_CYC(LOW), .HIGH_CYC(HIGH), .TMO_MS(TMO), .BREAK_FRAMES(NBRK), .BYTE_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .send_req(send_req), .send_data(send_data), .recv_req(recv_req),
        .line_in(line_in), .ms_tick(ms_tick), .eng_busy(eng_busy), .eng_dout(eng_dout),
        .data_out(data_out), .data_oe(data_oe), .clk_oe(clk_oe), .eng_start(eng_start),
        .eng_kind(eng_kind), .eng_byte(eng_byte), .req_ready(req_ready),
        .op_done(op_done), .tmo_err(tmo_err)
    );

    // Target side: pull-up on the released line
    assign line_in = data_oe ? data_out : pull_high;

    // Millisecond tick every four cycles
    int tick_cnt = 0;
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
    end
    assign ms_tick = (tick_cnt == 3);

    // Engine model: busy for a frame length after each start, freezable
    int eng_rem = 0;
    int eng_cur = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_rem <= 0;
        end else if (eng_start) begin
            eng_rem <= (eng_kind == 2'd1) ? 1 : FRAME_LEN;
            eng_cur <= int'(eng_kind);
        end else if (eng_rem > 0 && !hang) begin
            eng_rem <= eng_rem - 1;
        end
    end
    assign eng_busy = (eng_rem != 0);
    assign eng_dout = (eng_busy && eng_cur != 0) ? eng_rem[0] : 1'b1;

    // Reference model
    int mph = P_OFF;
    int mhold = 0;
    int mbrk = 0;
    int mtmo = TMO;
    bit mdir = 1'b0;
    bit merr = 1'b0;
    logic [7:0] mbyte = 8'h00;
    wire m_timed = (mph == P_RXPULL) || (mph == P_RXW) || (mph == P_DISPULL);

    always @(posedge clk) begin
        if (!rst_n) begin
            mph <= P_OFF; mdir <= 1'b0; merr <= 1'b0; mtmo <= TMO; mbrk <= 0; mhold <= 0;
            mbyte <= 8'h00;
        end else begin
            if (m_timed && ms_tick && mtmo > 0) mtmo <= mtmo - 1;
            case (mph)
                P_OFF: if (en_req) begin
                    mph <= P_LOW; mdir <= 1'b1; merr <= 1'b0; mhold <= LOW; mtmo <= TMO;
                end
                P_LOW: if (mhold == 1) begin mph <= P_HIGH; mhold <= HIGH; end
                       else mhold <= mhold - 1;
                P_HIGH: if (mhold == 1) begin mph <= P_BRKGO; mbrk <= NBRK; end
                        else mhold <= mhold - 1;
                P_BRKGO: if (!eng_busy) mph <= P_BRKW;
                P_BRKW: if (!eng_busy) begin
                    if (mbrk == 1) begin mph <= P_IDLE; mtmo <= TMO; end
                    else begin mbrk <= mbrk - 1; mph <= P_BRKGO; end
                end
                P_IDLE: begin
                    if (dis_req) begin
                        mtmo <= TMO;
                        if (mdir) mph <= P_DISDR;
                        else begin mph <= P_OFF; mdir <= 1'b0; end
                    end else if (send_req && !merr) begin
                        mtmo <= TMO; mbyte <= send_data;
                        mph <= mdir ? P_TXGO : P_DUMGO;
                    end else if (recv_req && !merr) begin
                        mtmo <= TMO;
                        mph <= mdir ? P_RXDR : P_RXGO;
                    end
                end
                P_DUMGO: if (!eng_busy) mph <= P_DUMW;
                P_DUMW: if (!eng_busy) begin mdir <= 1'b1; mph <= P_TXGO; end
                P_TXGO: if (!eng_busy) begin mtmo <= TMO; mph <= P_IDLE; end
                P_RXDR: if (!eng_busy) begin mdir <= 1'b0; mph <= P_RXPULL; end
                P_RXPULL: if (line_in) begin mtmo <= TMO; mph <= P_RXGO; end
                          else if (mtmo == 0) begin merr <= 1'b1; mph <= P_IDLE; end
                P_RXGO: if (!eng_busy) mph <= P_RXW;
                P_RXW: if (!eng_busy) begin mtmo <= TMO; mph <= P_IDLE; end
                       else if (mtmo == 0) begin merr <= 1'b1; mph <= P_IDLE; end
                P_DISDR: if (!eng_busy) begin mdir <= 1'b0; mph <= P_DISPULL; end
                P_DISPULL: if (line_in || mtmo == 0) begin
                    if (!line_in) merr <= 1'b1;
                    mph <= P_OFF; mdir <= 1'b0;
                end
                default: mph <= P_OFF;
            endcase
        end
    end

    // Model outputs
    wire e_clk   = (mph != P_OFF);
    wire e_oe    = e_clk && mdir;
    wire e_out   = !e_oe ? 1'b0 : (mph == P_LOW) ? 1'b0 : (eng_busy ? eng_dout : 1'b1);
    wire e_go    = (mph == P_BRKGO) || (mph == P_DUMGO) || (mph == P_TXGO) || (mph == P_RXGO);
    wire e_start = e_go && !eng_busy;
    wire [1:0] e_kind = (mph == P_DUMGO) ? 2'd1 : (mph == P_TXGO) ? 2'd2 :
                        (mph == P_RXGO) ? 2'd3 : 2'd0;
    wire e_done  = !eng_busy && ((mph == P_TXGO) || (mph == P_RXW));
    wire e_ready = (mph == P_IDLE) && !merr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2 clk_oe", clk_oe, e_clk);
            chk("R2 data_oe", data_oe, e_oe);
            chk("R2 data_out", data_out, e_out);
            chk("R3 eng_start", eng_start, e_start);
            if (e_start) chk("R4 eng_kind", eng_kind, e_kind);
            if (e_start && e_kind == 2'd2) chk("R5 eng_byte", eng_byte, mbyte);
            chk("R5 op_done", op_done, e_done);
            chk("R8 req_ready", req_ready, e_ready);
            chk("R7 tmo_err", tmo_err, merr);
        end
    end

    // Command log seen at the engine
    int k_log[$];
    bit oe_log[$];
    logic [7:0] b_log[$];
    always @(negedge clk) begin
        if (rst_n && eng_start) begin
            k_log.push_back(int'(eng_kind));
            oe_log.push_back(data_oe);
            b_log.push_back(eng_byte);
        end
    end

    task automatic clear_log();
        k_log.delete(); oe_log.delete(); b_log.delete();
    endtask

    task automatic wait_ready(input int lim);
        for (int i = 0; i < lim; i++) begin
            if (req_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    bit finished = 1'b0;

    initial begin : watchdog
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R1: reset state
        chk("R1 clk_oe", clk_oe, 0);
        chk("R1 data_oe", data_oe, 0);
        chk("R1 req_ready", req_ready, 0);
        chk("R1 tmo_err", tmo_err, 0);
        chk("R1 eng_start", eng_start, 0);

        // R2: entry hold low then high
        en_req = 1'b1; @(negedge clk); en_req = 1'b0;
        n = 0;
        while (data_oe && !data_out && n < 1000) begin n++; @(negedge clk); end
        chk("R2 low cycles", n, LOW);
        n = 0;
        while (data_oe && data_out && !eng_start && n < 1000) begin n++; @(negedge clk); end
        chk("R2 high cycles", n, HIGH);

        // R3: idle frames then ready in transmit direction
        wait_ready(200);
        chk("R3 break count", k_log.size(), NBRK);
        chk("R3 first kind", (k_log.size() > 0) ? k_log[0] : 9, 0);
        chk("R3 ready", req_ready, 1);
        chk("R3 tx dir", data_oe, 1);

        // R5: send in transmit direction, no dummy bit
        clear_log();
        send_data = 8'hA5; send_req = 1'b1; @(negedge clk); send_req = 1'b0;
        wait_ready(50);
        chk("R5 one command", k_log.size(), 1);
        chk("R5 send kind", (k_log.size() > 0) ? k_log[0] : 9, 2);
        chk("R5 byte", (b_log.size() > 0) ? b_log[0] : 8'h00, 8'hA5);

        // R6: receive after transmit
        clear_log();
        recv_req = 1'b1; @(negedge clk); recv_req = 1'b0;
        idle_cycles(2);
        wait_ready(200);
        chk("R6 one command", k_log.size(), 1);
        chk("R6 recv kind", (k_log.size() > 0) ? k_log[0] : 9, 3);
        chk("R6 released at start", (oe_log.size() > 0) ? oe_log[0] : 1'b1, 0);
        chk("R6 no error", tmo_err, 0);

        // R4: send from receive direction
        clear_log();
        send_data = 8'h3C; send_req = 1'b1; @(negedge clk); send_req = 1'b0;
        wait_ready(50);
        chk("R4 two commands", k_log.size(), 2);
        chk("R4 dummy first", (k_log.size() > 1) ? k_log[0] : 9, 1);
        chk("R4 dummy released", (oe_log.size() > 1) ? oe_log[0] : 1'b1, 0);
        chk("R4 send second", (k_log.size() > 1) ? k_log[1] : 9, 2);
        chk("R4 send driven", (oe_log.size() > 1) ? oe_log[1] : 1'b0, 1);
        chk("R4 byte", (b_log.size() > 1) ? b_log[1] : 8'h00, 8'h3C);

        // R10: send wins over receive
        clear_log();
        send_data = 8'h5A; send_req = 1'b1; recv_req = 1'b1; @(negedge clk);
        send_req = 1'b0; recv_req = 1'b0;
        wait_ready(50);
        idle_cycles(4);
        chk("R10 send only", k_log.size(), 1);
        chk("R10 kind", (k_log.size() > 0) ? k_log[0] : 9, 2);

        // R7: receive with a stalled engine times out
        recv_req = 1'b1; @(negedge clk); recv_req = 1'b0;
        n = 0;
        while (!(eng_start && eng_kind == 2'd3) && n < 200) begin n++; @(negedge clk); end
        hang = 1'b1;
        clear_log();
        n = 0;
        while (!tmo_err && n < 200) begin n++; @(negedge clk); end
        chk("R7 error set", tmo_err, 1);
        chk("R7 timeout window", (n >= 4 * (TMO - 1)) ? 1 : 0, 1);
        hang = 1'b0;
        idle_cycles(20);

        // R8: requests blocked while in error
        clear_log();
        send_req = 1'b1; @(negedge clk); send_req = 1'b0;
        idle_cycles(5);
        recv_req = 1'b1; @(negedge clk); recv_req = 1'b0;
        idle_cycles(30);
        chk("R8 no commands", k_log.size(), 0);
        chk("R8 not ready", req_ready, 0);
        chk("R8 error held", tmo_err, 1);

        // R9: disable in receive direction
        dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
        chk("R9 clk released", clk_oe, 0);
        chk("R9 data released", data_oe, 0);

        // R7: enable clears the error
        en_req = 1'b1; @(negedge clk); en_req = 1'b0;
        chk("R7 error cleared", tmo_err, 0);
        wait_ready(300);
        chk("R7 ready again", req_ready, 1);

        // R7: line never pulled high
        pull_high = 1'b0;
        clear_log();
        recv_req = 1'b1; @(negedge clk); recv_req = 1'b0;
        n = 0;
        while (!tmo_err && n < 200) begin n++; @(negedge clk); end
        chk("R7 pull timeout", tmo_err, 1);
        chk("R7 no receive issued", k_log.size(), 0);
        chk("R7 line released", data_oe, 0);
        pull_high = 1'b1;

        // R10 and R9: disable wins over send, transmit-direction disable path
        dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
        en_req = 1'b1; @(negedge clk); en_req = 1'b0;
        wait_ready(300);
        clear_log();
        dis_req = 1'b1; send_req = 1'b1; @(negedge clk);
        dis_req = 1'b0; send_req = 1'b0;
        chk("R9 clock kept during drain", clk_oe, 1);
        idle_cycles(10);
        chk("R10 no send", k_log.size(), 0);
        chk("R9 clk off", clk_oe, 0);
        chk("R9 data off", data_oe, 0);
        chk("R9 no error", tmo_err, 0);

        idle_cycles(3);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule